// File: doc/BRIEF.md
# Reconfiguration Trigger Monitor

This block watches per-slot utilisation samples from a set of hardware module slots. From them it decides when the slot mix should change and what the new mix should be. Each accepted sample is compared, slot by slot, with that slot's own threshold. A run counter tracks how many samples in a row exceeded it. When a run reaches the programmed length, the block forms a target configuration. The overloaded module type gains one slot, taken from the least-busy slot of another type. The block measures how many slots that target would change. It issues the target only if that cost is within a programmed limit.

Samples enter on a valid/ready stream, and the trigger leaves on a valid/ready stream. Back-pressure works as follows: while a trigger waits on the output, `samp_ready` is low, so the sample stream stalls and no sample is lost or counted twice. Once a trigger has been issued, further triggers are held off until `recfg_done` reports that the reconfiguration has finished. Carrying out the reconfiguration is left to other logic.

Top module: `reconf_trigger_monitor`

## Requirements
- R1: After reset `trig_valid` is low and `samp_ready` is high.
- R2: A sample counts as a violation for slot i when `samp_util[8i+7:8i]` is strictly greater than `cfg_thresh[8i+7:8i]`. A non-violating sample restarts that slot's run. A trigger needs `cfg_run_len` consecutive violations (1 to 15); the value 0 acts as 1.
- R3: A trigger caused by an accepted sample appears on `trig_valid` in the cycle after the sample is accepted.
- R4: Slot i's module type is `cur_cfg[2i+1:2i]`. The overloaded type is the type of the lowest-numbered slot whose run completed. The target gives that type to the slot of a different type with the smallest utilisation in the same sample; on a tie the lowest-numbered slot wins. All other slots keep their types.
- R5: `trig_cost` is the number of slots whose type differs between target and `cur_cfg`. A target is issued only if the cost does not exceed `cfg_cost_max`. A suppressed target leaves the run counters counting, and they saturate at 15, so raising the limit lets the next violating sample trigger.
- R6: If every slot already holds the overloaded type, no trigger is issued.
- R7: Issuing a trigger clears every run counter. Samples accepted afterwards do not count until `recfg_done` is pulsed.
- R8: A sample accepted in the same cycle as `recfg_done` is evaluated as unblocked, counting from zero.
- R9: `trig_valid`, `trig_cfg` and `trig_cost` hold steady until `trig_ready` is high. `samp_ready` is low whenever `trig_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| samp_valid | input | 1 | Sample vector is valid |
| samp_ready | output | 1 | Monitor accepts a sample |
| samp_util | input | 24 | Utilisation per slot, 8 bits each, slot 0 lowest |
| cfg_thresh | input | 24 | Threshold per slot, same packing |
| cfg_run_len | input | 4 | Consecutive violations needed |
| cfg_cost_max | input | 2 | Largest allowed transition cost |
| cur_cfg | input | 6 | Present module type per slot, 2 bits each |
| recfg_done | input | 1 | Reconfiguration finished, lifts the block |
| trig_valid | output | 1 | Trigger pending |
| trig_ready | input | 1 | Consumer takes the trigger |
| trig_cfg | output | 6 | Target configuration |
| trig_cost | output | 2 | Slots changed by the target |

## Verification
Two functions can fall in the same cycle. The release of the post-trigger block by `recfg_done` can coincide with an accepted sample that completes a run. The bench sets a run length of one and leaves the block raised. It then drives a violating sample together with the `recfg_done` pulse. A trigger must follow in the next cycle. A separate test shows that the same sample without the pulse is ignored while the block is raised.

// File: rtl/rtm_pkg.sv
package rtm_pkg;
  localparam int unsigned DEF_SLOTS  = 3;
  localparam int unsigned DEF_TYPE_W = 2;
  localparam int unsigned DEF_UTIL_W = 8;
  localparam int unsigned DEF_RUN_W  = 4;

  // width of an index able to address n items (at least 1 bit)
  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/rtm_run_ctr.sv
module rtm_run_ctr #(
  parameter int unsigned UTIL_W = rtm_pkg::DEF_UTIL_W,
  parameter int unsigned RUN_W  = rtm_pkg::DEF_RUN_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_acc,
  input  logic              clear,
  input  logic [UTIL_W-1:0] util,
  input  logic [UTIL_W-1:0] thresh,
  input  logic [RUN_W-1:0]  run_need,
  output logic              hot
);
  logic [RUN_W-1:0] cnt_q;
  logic [RUN_W-1:0] cnt_nxt;
  logic             over;

  always_comb begin
    over = util > thresh;
    if (!over)
      cnt_nxt = '0;
    else if (cnt_q == '1)
      cnt_nxt = cnt_q;
    else
      cnt_nxt = cnt_q + RUN_W'(1);
    hot = over && (cnt_nxt >= run_need);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (smp_acc)
      cnt_q <= clear ? '0 : cnt_nxt;
  end
endmodule

// File: rtl/rtm_target_pick.sv
module rtm_target_pick #(
  parameter int unsigned SLOTS  = rtm_pkg::DEF_SLOTS,
  parameter int unsigned TYPE_W = rtm_pkg::DEF_TYPE_W,
  parameter int unsigned UTIL_W = rtm_pkg::DEF_UTIL_W
) (
  input  logic [SLOTS-1:0]        hot,
  input  logic [SLOTS*TYPE_W-1:0] cur_cfg,
  input  logic [SLOTS*UTIL_W-1:0] util,
  output logic                    found,
  output logic [SLOTS*TYPE_W-1:0] tgt_cfg
);
  localparam int unsigned IDX_W = rtm_pkg::idx_width(SLOTS);

  logic [TYPE_W-1:0] cur_a [SLOTS];
  logic [UTIL_W-1:0] util_a [SLOTS];
  logic [TYPE_W-1:0] tgt_a [SLOTS];

  for (genvar g = 0; g < SLOTS; g++) begin : g_unpack
    assign cur_a[g]  = cur_cfg[g*TYPE_W +: TYPE_W];
    assign util_a[g] = util[g*UTIL_W +: UTIL_W];
    assign tgt_cfg[g*TYPE_W +: TYPE_W] = tgt_a[g];
  end

  logic              have_hot;
  logic [IDX_W-1:0]  hot_idx;
  logic [TYPE_W-1:0] ovl_type;
  logic              have_cand;
  logic [IDX_W-1:0]  cand_idx;
  logic [UTIL_W-1:0] cand_util;

  // lowest-numbered slot with a completed run names the overloaded type
  always_comb begin
    have_hot = 1'b0;
    hot_idx  = '0;
    for (int i = 0; i < SLOTS; i++) begin
      if (hot[i] && !have_hot) begin
        have_hot = 1'b1;
        hot_idx  = IDX_W'(i);
      end
    end
    ovl_type = cur_a[hot_idx];
  end

  // least-utilised slot of another type, ties to the lowest number
  always_comb begin
    have_cand = 1'b0;
    cand_idx  = '0;
    cand_util = '0;
    for (int j = 0; j < SLOTS; j++) begin
      if (cur_a[j] != ovl_type && (!have_cand || util_a[j] < cand_util)) begin
        have_cand = 1'b1;
        cand_idx  = IDX_W'(j);
        cand_util = util_a[j];
      end
    end
  end

  always_comb begin
    for (int k = 0; k < SLOTS; k++)
      tgt_a[k] = (have_cand && IDX_W'(k) == cand_idx) ? ovl_type : cur_a[k];
    found = have_hot && have_cand;
  end
endmodule

// File: rtl/rtm_cost_eval.sv
module rtm_cost_eval #(
  parameter int unsigned SLOTS  = rtm_pkg::DEF_SLOTS,
  parameter int unsigned TYPE_W = rtm_pkg::DEF_TYPE_W,
  parameter int unsigned COST_W = $clog2(SLOTS + 1)
) (
  input  logic [SLOTS*TYPE_W-1:0] cfg_a,
  input  logic [SLOTS*TYPE_W-1:0] cfg_b,
  input  logic [COST_W-1:0]       limit,
  output logic [COST_W-1:0]       cost,
  output logic                    allowed
);
  logic [SLOTS-1:0] diff;

  for (genvar g = 0; g < SLOTS; g++) begin : g_diff
    assign diff[g] = cfg_a[g*TYPE_W +: TYPE_W] != cfg_b[g*TYPE_W +: TYPE_W];
  end

  always_comb begin
    cost = '0;
    for (int i = 0; i < SLOTS; i++)
      if (diff[i]) cost = cost + COST_W'(1);
    allowed = cost <= limit;
  end
endmodule

// File: rtl/reconf_trigger_monitor.sv
module reconf_trigger_monitor #(
  parameter int unsigned SLOTS  = rtm_pkg::DEF_SLOTS,
  parameter int unsigned TYPE_W = rtm_pkg::DEF_TYPE_W,
  parameter int unsigned UTIL_W = rtm_pkg::DEF_UTIL_W,
  parameter int unsigned RUN_W  = rtm_pkg::DEF_RUN_W
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         samp_valid,
  output logic                         samp_ready,
  input  logic [SLOTS*UTIL_W-1:0]      samp_util,
  input  logic [SLOTS*UTIL_W-1:0]      cfg_thresh,
  input  logic [RUN_W-1:0]             cfg_run_len,
  input  logic [$clog2(SLOTS+1)-1:0]   cfg_cost_max,
  input  logic [SLOTS*TYPE_W-1:0]      cur_cfg,
  input  logic                         recfg_done,
  output logic                         trig_valid,
  input  logic                         trig_ready,
  output logic [SLOTS*TYPE_W-1:0]      trig_cfg,
  output logic [$clog2(SLOTS+1)-1:0]   trig_cost
);
  localparam int unsigned COST_W = $clog2(SLOTS + 1);
  localparam int unsigned CFG_W  = SLOTS * TYPE_W;

  logic              blocked_q;
  logic              trig_valid_q;
  logic [CFG_W-1:0]  trig_cfg_q;
  logic [COST_W-1:0] trig_cost_q;

  logic              smp_acc;
  logic              unblk;
  logic              fire;
  logic [RUN_W-1:0]  run_need;
  logic [SLOTS-1:0]  hot;
  logic              found;
  logic [CFG_W-1:0]  tgt_cfg;
  logic [COST_W-1:0] cost;
  logic              allowed;

  assign samp_ready = !trig_valid_q;
  assign smp_acc    = samp_valid && samp_ready;
  assign unblk      = !blocked_q || recfg_done;
  assign run_need   = (cfg_run_len == '0) ? RUN_W'(1) : cfg_run_len;
  assign fire       = smp_acc && unblk && found && allowed;

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    rtm_run_ctr #(
      .UTIL_W(UTIL_W),
      .RUN_W (RUN_W)
    ) u_run (
      .clk     (clk),
      .rst_n   (rst_n),
      .smp_acc (smp_acc),
      .clear   (fire || !unblk),
      .util    (samp_util[g*UTIL_W +: UTIL_W]),
      .thresh  (cfg_thresh[g*UTIL_W +: UTIL_W]),
      .run_need(run_need),
      .hot     (hot[g])
    );
  end

  rtm_target_pick #(
    .SLOTS (SLOTS),
    .TYPE_W(TYPE_W),
    .UTIL_W(UTIL_W)
  ) u_pick (
    .hot    (hot),
    .cur_cfg(cur_cfg),
    .util   (samp_util),
    .found  (found),
    .tgt_cfg(tgt_cfg)
  );

  rtm_cost_eval #(
    .SLOTS (SLOTS),
    .TYPE_W(TYPE_W),
    .COST_W(COST_W)
  ) u_cost (
    .cfg_a  (tgt_cfg),
    .cfg_b  (cur_cfg),
    .limit  (cfg_cost_max),
    .cost   (cost),
    .allowed(allowed)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      blocked_q    <= 1'b0;
      trig_valid_q <= 1'b0;
      trig_cfg_q   <= '0;
      trig_cost_q  <= '0;
    end else begin
      if (fire)
        blocked_q <= 1'b1;
      else if (recfg_done)
        blocked_q <= 1'b0;

      if (fire) begin
        trig_valid_q <= 1'b1;
        trig_cfg_q   <= tgt_cfg;
        trig_cost_q  <= cost;
      end else if (trig_ready) begin
        trig_valid_q <= 1'b0;
      end
    end
  end

  assign trig_valid = trig_valid_q;
  assign trig_cfg   = trig_cfg_q;
  assign trig_cost  = trig_cost_q;
endmodule

// File: rtl/reconf_trigger_monitor_chk.sv
module reconf_trigger_monitor_chk #(
  parameter int unsigned SLOTS  = rtm_pkg::DEF_SLOTS,
  parameter int unsigned TYPE_W = rtm_pkg::DEF_TYPE_W
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       samp_valid,
  input logic                       samp_ready,
  input logic                       recfg_done,
  input logic                       trig_valid,
  input logic                       trig_ready,
  input logic [SLOTS*TYPE_W-1:0]    trig_cfg,
  input logic [$clog2(SLOTS+1)-1:0] trig_cost,
  input logic [$clog2(SLOTS+1)-1:0] cfg_cost_max
);
  logic tv_q;
  logic armed_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tv_q    <= 1'b0;
      armed_q <= 1'b1;
    end else begin
      tv_q    <= trig_valid;
      armed_q <= recfg_done || (armed_q && !(trig_valid && !tv_q));
    end
  end

  AST_SAMPLE_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    trig_valid |-> !samp_ready); // R9
  AST_TRIG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_valid && !trig_ready) |=> (trig_valid && $stable(trig_cfg) && $stable(trig_cost))); // R9
  AST_TRIG_FROM_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trig_valid) |-> $past(samp_valid && samp_ready)); // R3
  AST_COST_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trig_valid) |-> (trig_cost <= $past(cfg_cost_max))); // R5
  AST_COST_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    trig_valid |-> (trig_cost != '0)); // R4
  AST_ONE_PER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trig_valid) |-> ($past(armed_q) || $past(recfg_done))); // R7
endmodule

bind reconf_trigger_monitor reconf_trigger_monitor_chk #(
  .SLOTS (SLOTS),
  .TYPE_W(TYPE_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .samp_valid  (samp_valid),
  .samp_ready  (samp_ready),
  .recfg_done  (recfg_done),
  .trig_valid  (trig_valid),
  .trig_ready  (trig_ready),
  .trig_cfg    (trig_cfg),
  .trig_cost   (trig_cost),
  .cfg_cost_max(cfg_cost_max)
);

// File: tb/reconf_trigger_monitor_tb.sv
module reconf_trigger_monitor_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        samp_valid = 1'b0;
  logic        samp_ready;
  logic [23:0] samp_util = '0;
  logic [23:0] cfg_thresh = {8'd200, 8'd150, 8'd100};
  logic [3:0]  cfg_run_len = 4'd3;
  logic [1:0]  cfg_cost_max = 2'd1;
  logic [5:0]  cur_cfg = 6'b10_01_00;
  logic        recfg_done = 1'b0;
  logic        trig_valid;
  logic        trig_ready = 1'b1;
  logic [5:0]  trig_cfg;
  logic [1:0]  trig_cost;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  reconf_trigger_monitor u_dut (
    .clk(clk), .rst_n(rst_n), .samp_valid(samp_valid), .samp_ready(samp_ready),
    .samp_util(samp_util), .cfg_thresh(cfg_thresh), .cfg_run_len(cfg_run_len),
    .cfg_cost_max(cfg_cost_max), .cur_cfg(cur_cfg), .recfg_done(recfg_done),
    .trig_valid(trig_valid), .trig_ready(trig_ready), .trig_cfg(trig_cfg),
    .trig_cost(trig_cost)
  );

  // {util slot2, slot1, slot0, expect trigger, expected target}
  localparam logic [30:0] VEC [15] = '{
    {8'd10,  8'd20,  8'd101, 1'b0, 6'b000000},
    {8'd10,  8'd20,  8'd150, 1'b0, 6'b000000},
    {8'd10,  8'd20,  8'd100, 1'b0, 6'b000000},
    {8'd10,  8'd20,  8'd120, 1'b0, 6'b000000},
    {8'd10,  8'd20,  8'd120, 1'b0, 6'b000000},
    {8'd30,  8'd20,  8'd120, 1'b1, 6'b100000},
    {8'd201, 8'd5,   8'd0,   1'b0, 6'b000000},
    {8'd201, 8'd5,   8'd0,   1'b0, 6'b000000},
    {8'd255, 8'd5,   8'd9,   1'b1, 6'b101000},
    {8'd250, 8'd7,   8'd7,   1'b0, 6'b000000},
    {8'd250, 8'd7,   8'd7,   1'b0, 6'b000000},
    {8'd250, 8'd7,   8'd7,   1'b1, 6'b100110},
    {8'd210, 8'd160, 8'd0,   1'b0, 6'b000000},
    {8'd210, 8'd160, 8'd0,   1'b0, 6'b000000},
    {8'd210, 8'd160, 8'd0,   1'b1, 6'b100101}
  };

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic send(input logic [23:0] u, input logic with_done);
    @(negedge clk);
    while (!samp_ready) @(negedge clk);
    samp_util  = u;
    samp_valid = 1'b1;
    recfg_done = with_done;
    @(negedge clk);
    samp_valid = 1'b0;
    recfg_done = 1'b0;
  endtask

  task automatic expect_trig(input bit exp, input logic [5:0] cfg, input string req);
    check(trig_valid == exp, req, "trig_valid", int'(trig_valid), int'(exp));
    if (exp) begin
      check(trig_cfg == cfg, req, "trig_cfg", int'(trig_cfg), int'(cfg));
      check(trig_cost == 2'd1, req, "trig_cost", int'(trig_cost), 1);
    end
  endtask

  task automatic pulse_done();
    @(negedge clk);
    recfg_done = 1'b1;
    @(negedge clk);
    recfg_done = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog R3 actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: state straight after reset
    check(trig_valid == 1'b0, "R1", "trig_valid", int'(trig_valid), 0);
    check(samp_ready == 1'b1, "R1", "samp_ready", int'(samp_ready), 1);
    rst_n = 1'b1;

    // R2 R3 R4: runs, strict compare, target choice, ties and priority
    foreach (VEC[i]) begin
      send(VEC[i][30:7], 1'b0);
      expect_trig(VEC[i][6], VEC[i][5:0], "R2/R4");
      if (VEC[i][6]) pulse_done();
    end

    // R7: trigger, then samples ignored until done, then count from zero
    for (int n = 0; n < 3; n++) send({8'd210, 8'd0, 8'd0}, 1'b0);
    expect_trig(1'b1, 6'b100110, "R7");
    for (int n = 0; n < 3; n++) begin
      send({8'd210, 8'd0, 8'd0}, 1'b0);
      expect_trig(1'b0, 6'b0, "R7");
    end
    pulse_done();
    for (int n = 0; n < 2; n++) begin
      send({8'd210, 8'd0, 8'd0}, 1'b0);
      expect_trig(1'b0, 6'b0, "R7");
    end
    send({8'd210, 8'd0, 8'd0}, 1'b0);
    expect_trig(1'b1, 6'b100110, "R7");
    pulse_done();

    // R9: trigger held under back-pressure, samples stalled
    cfg_run_len = 4'd1;
    trig_ready  = 1'b0;
    send({8'd0, 8'd0, 8'd101}, 1'b0);
    expect_trig(1'b1, 6'b100000, "R9");
    for (int n = 0; n < 3; n++) begin
      @(negedge clk);
      check(trig_valid == 1'b1, "R9", "trig_valid held", int'(trig_valid), 1);
      check(trig_cfg == 6'b100000, "R9", "trig_cfg held", int'(trig_cfg), 32);
      check(samp_ready == 1'b0, "R9", "samp_ready", int'(samp_ready), 0);
    end
    trig_ready = 1'b1;
    @(negedge clk);
    check(trig_valid == 1'b0, "R9", "trig_valid after ready", int'(trig_valid), 0);
    pulse_done();

    // R8: done in the same cycle as a completing sample
    send({8'd0, 8'd0, 8'd101}, 1'b0);
    expect_trig(1'b1, 6'b100000, "R8");
    send({8'd0, 8'd0, 8'd101}, 1'b1);
    expect_trig(1'b1, 6'b100000, "R8");
    pulse_done();

    // R2: run length 0 acts as 1
    cfg_run_len = 4'd0;
    send({8'd0, 8'd0, 8'd101}, 1'b0);
    expect_trig(1'b1, 6'b100000, "R2");
    pulse_done();

    // R5: cost limit 0 suppresses, counters saturate, raised limit fires
    cfg_run_len  = 4'd15;
    cfg_cost_max = 2'd0;
    for (int n = 0; n < 20; n++) begin
      send({8'd0, 8'd0, 8'd101}, 1'b0);
      expect_trig(1'b0, 6'b0, "R5");
    end
    cfg_cost_max = 2'd1;
    send({8'd0, 8'd0, 8'd101}, 1'b0);
    expect_trig(1'b1, 6'b100000, "R5");
    pulse_done();

    // R6: no slot of another type, no trigger
    cfg_run_len = 4'd1;
    cur_cfg     = 6'b00_00_00;
    send({8'd0, 8'd0, 8'd101}, 1'b0);
    expect_trig(1'b0, 6'b0, "R6");
    cur_cfg = 6'b10_01_00;
    send({8'd0, 8'd0, 8'd101}, 1'b0);
    expect_trig(1'b1, 6'b100000, "R6");
    pulse_done();

    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule